// File: doc/BRIEF.md
# External Memory Strobe Timing Generator

This block shapes the control strobes of one external memory bank. Its clock ticks once per phase, where a phase is half of a bus cycle. Each accepted request starts an access whose length is set by a duration field in whole cycles. The active-low chip-enable, output-enable and per-byte write strobes switch at phase resolution. Each strobe turns on a programmable number of phases after the access starts and turns off a programmable number of phases before the access ends.

A write also opens a data-bus drive window after a short delay. A read produces a one-phase capture pulse in its last phase. The memory can stretch an access with a wait input. After every access the block leaves a bus-release gap before it accepts the next request. A read-only bank turns away writes with an error.

The configuration fields sit in a register. Reset loads them with slow timing that suits ROM and SRAM. The bus width comes from two boot-select pins that are sampled while reset is held.

Top module: `mem_strobe_gen`

## Requirements
- R1: While reset is held and after it is released, the block presents these defaults: duration 10 cycles (20 phases), chip-enable on 0 and off 0, output-enable on 0, write-strobe on 9 and off 2, release 2 cycles, drive delay 5 phases, wait enabled and writes allowed. In the same state `req_ready` is 1, `ce_n`, `oe_n` and `we_n` are all 1, and `data_oe`, `rd_capture`, `done` and `err` are 0.
- R2: `bus_wide` is loaded while reset is held. It becomes 0 (8-bit) when `boot_src` is 2'b01 and 1 (16-bit) for any other code. In 8-bit mode `we_n[1]` never goes low.
- R3: A request accepted at clock edge k (with `req_valid` and `req_ready` both 1) makes the phase after edge k+p access phase p. The access has L phases, where L is twice the duration field, and a duration of 0 gives L = 32. `done` is 1 for exactly one clock, in the phase after the last access phase.
- R4: `ce_n` is 0 exactly in the phases p with ce_on ≤ p < L − ce_off.
- R5: On a read, `oe_n` is 0 for oe_on ≤ p < L. `rd_capture` is 1 in phase L−1 only, and only in a phase that is not held by wait.
- R6: On a write, `we_n[i]` is 0 for we_on ≤ p < L − we_off, for each lane i whose `req_lanes[i]` was 1 at acceptance. Reads never drive `we_n` low.
- R7: On a write, `data_oe` is 1 for drive_delay ≤ p < L. On a read it stays 0.
- R8: The hold phase is H = L − 1 − off, where off is ce_off on reads and max(ce_off, we_off) on writes; H is 0 if off ≥ L. While wait is enabled, the access is in phase H and `mem_wait` is 1, the phase does not advance and all strobes hold their levels. Counting resumes at the edge after `mem_wait` falls. When wait is disabled, `mem_wait` has no effect.
- R9: A write request to a read-only bank drives no strobe. `done` and `err` are both 1 in the phase after acceptance.
- R10: After `done`, `req_ready` stays 0 for 2 × release phases counted from the `done` phase, with all strobes inactive. It then returns to 1. With release 0, `req_ready` is already 1 in the `done` phase.
- R11: When a strobe's off point is at or before its on point, that strobe stays 1 for the whole access.
- R12: `cfg_wr` loads all configuration fields at a clock edge only while `req_ready` is 1. At any other time it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one tick per half bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_src | input | 2 | Boot-select pins that set the bus width during reset |
| cfg_wr | input | 1 | Load the configuration fields |
| cfg_dur | input | 4 | Access length in cycles (0 = 16 cycles) |
| cfg_ce_on | input | 4 | Chip-enable on point, phases from start |
| cfg_ce_off | input | 4 | Chip-enable off point, phases before end |
| cfg_oe_on | input | 4 | Output-enable on point, phases from start |
| cfg_we_on | input | 4 | Write-strobe on point, phases from start |
| cfg_we_off | input | 4 | Write-strobe off point, phases before end |
| cfg_release | input | 2 | Bus-release gap in cycles |
| cfg_drive_dly | input | 3 | Write data-drive delay in phases |
| cfg_wait_en | input | 1 | Allow the wait input to stretch accesses |
| cfg_read_only | input | 1 | Bank rejects writes |
| cfg_bus_wide | input | 1 | Bus width, 1 = 16-bit |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lanes | input | 2 | Byte lanes to strobe on a write |
| req_ready | output | 1 | Block is idle and takes a request |
| mem_wait | input | 1 | Memory wait input |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 2 | Per-lane write strobes, active low |
| data_oe | output | 1 | Data-bus output enable for writes |
| rd_capture | output | 1 | Read data capture pulse |
| done | output | 1 | Access finished, one clock |
| err | output | 1 | Write to read-only bank, with done |
| bus_wide | output | 1 | Current bus width |

## Verification
Every output in phase p of an access is due one clock after edge k+p. `done` is due one clock after the last phase edge, and `req_ready` returns 2 × release clocks after that. Each hold phase pushes all later items back by one. For every request, the driver turns the configuration model into one expected item per clock. This covers every access phase, every hold, the `done` phase, every release phase and one idle phase. The monitor pops one item per clock a moment after the falling edge, so the registered state has settled and no result depends on process order at the active edge. The driver raises `mem_wait` at the falling edge inside the clock it means to stretch, and the same model decides whether that clock holds.

// File: rtl/strobe_pkg.sv
// Package: shared field widths, reset defaults, configuration type and the
// phase-window helpers used by the strobe timing generator.
// Assumes the phase counter is wide enough to hold twice the largest duration.
package strobe_pkg;

    localparam int DUR_W  = 4;              // duration field, in cycles
    localparam int EDGE_W = 4;              // strobe on/off fields, in phases
    localparam int REL_W  = 2;              // release gap, in cycles
    localparam int DLY_W  = 3;              // drive delay, in phases
    localparam int BOOT_W = 2;              // boot-select pins
    localparam int PH_W   = DUR_W + 2;      // phase counter width
    localparam int CMP_W  = PH_W + 1;       // compare width without overflow
    localparam int RPH_W  = REL_W + 1;      // release phase counter width

    localparam logic [BOOT_W-1:0] BOOT_NARROW = 2'b01;

    localparam logic [DUR_W-1:0]  RST_DUR    = 4'd10;
    localparam logic [EDGE_W-1:0] RST_CE_ON  = 4'd0;
    localparam logic [EDGE_W-1:0] RST_CE_OFF = 4'd0;
    localparam logic [EDGE_W-1:0] RST_OE_ON  = 4'd0;
    localparam logic [EDGE_W-1:0] RST_WE_ON  = 4'd9;
    localparam logic [EDGE_W-1:0] RST_WE_OFF = 4'd2;
    localparam logic [REL_W-1:0]  RST_REL    = 2'd2;
    localparam logic [DLY_W-1:0]  RST_DLY    = 3'd5;

    typedef struct packed {
        logic              bus_wide;
        logic              wait_en;
        logic              rd_only;
        logic [DUR_W-1:0]  dur;
        logic [EDGE_W-1:0] ce_on;
        logic [EDGE_W-1:0] ce_off;
        logic [EDGE_W-1:0] oe_on;
        logic [EDGE_W-1:0] we_on;
        logic [EDGE_W-1:0] we_off;
        logic [REL_W-1:0]  rel;
        logic [DLY_W-1:0]  dly;
    } cfg_t;

    // Slow default timing with the bus width chosen by the caller.
    function automatic cfg_t cfg_default(input logic wide);
        cfg_t c;
        c.bus_wide = wide;
        c.wait_en  = 1'b1;
        c.rd_only  = 1'b0;
        c.dur      = RST_DUR;
        c.ce_on    = RST_CE_ON;
        c.ce_off   = RST_CE_OFF;
        c.oe_on    = RST_OE_ON;
        c.we_on    = RST_WE_ON;
        c.we_off   = RST_WE_OFF;
        c.rel      = RST_REL;
        c.dly      = RST_DLY;
        return c;
    endfunction

    // Access length in phases; a zero duration means the longest access.
    function automatic logic [PH_W-1:0] access_len(input logic [DUR_W-1:0] dur);
        if (dur == '0)
            return PH_W'(2 ** (DUR_W + 1));
        return {1'b0, dur, 1'b0};
    endfunction

    // True when phase ph lies in [on, len - off).
    function automatic logic in_window(input logic [PH_W-1:0]   ph,
                                       input logic [EDGE_W-1:0] on,
                                       input logic [EDGE_W-1:0] off,
                                       input logic [PH_W-1:0]   len);
        logic [CMP_W-1:0] p, a, b, l;
        p = CMP_W'(ph);
        a = CMP_W'(on);
        b = CMP_W'(off);
        l = CMP_W'(len);
        return (p >= a) && ((p + b) < l);
    endfunction

endpackage

// File: rtl/strobe_cfg_regs.sv
// Configuration register for one bank. Reset loads the slow defaults. The bus
// width comes from the boot-select pins, sampled every clock while reset is low.
// A write is taken only while the sequencer is idle, so the fields stay fixed
// for the whole of an access and its release gap.
module strobe_cfg_regs
    import strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BOOT_W-1:0] boot_src,
    input  logic              cfg_wr,
    input  logic              idle,
    input  cfg_t              cfg_in,
    output cfg_t              cfg
);

    logic boot_wide;

    // Decode the boot-select pins into a bus width.
    always_comb boot_wide = (boot_src != BOOT_NARROW);

    // Hold the configuration; defaults on reset, loads only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= cfg_default(boot_wide);
        else if (cfg_wr && idle)
            cfg <= cfg_in;
    end

endmodule

// File: rtl/strobe_sequencer.sv
// Access sequencer: accepts a request, runs the phase counter through the
// access, holds it at the hold point while the memory asks to wait, and then
// counts the bus-release gap. It rejects writes to a read-only bank.
// Assumes the configuration does not change outside the idle state.
module strobe_sequencer
    import strobe_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUR_W-1:0]  dur,
    input  logic [EDGE_W-1:0] ce_off,
    input  logic [EDGE_W-1:0] we_off,
    input  logic [REL_W-1:0]  rel,
    input  logic              wait_en,
    input  logic              rd_only,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_lanes,
    input  logic              mem_wait,
    output logic              ready,
    output logic              active,
    output logic [PH_W-1:0]   phase,
    output logic [PH_W-1:0]   len,
    output logic              acc_write,
    output logic [LANES-1:0]  acc_lanes,
    output logic              stall,
    output logic              done,
    output logic              err
);

    typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_REL} seq_state_t;

    seq_state_t        state;
    logic [RPH_W-1:0]  rel_cnt;
    logic [RPH_W-1:0]  rel_len;
    logic              rel_none;
    logic [EDGE_W-1:0] tail_off;
    logic [PH_W-1:0]   hold_pt;
    logic              last_ph;
    logic              reject;

    // Access length and release length in phases.
    always_comb begin
        len      = access_len(dur);
        rel_len  = {rel, 1'b0};
        rel_none = (rel == '0);
    end

    // Hold point: the phase just before the earliest strobe off point.
    always_comb begin
        tail_off = (acc_write && (we_off > ce_off)) ? we_off : ce_off;
        hold_pt  = (len > PH_W'(tail_off)) ? (len - PH_W'(tail_off) - PH_W'(1)) : '0;
    end

    // State decode, stall condition and the rejection of a forbidden write.
    always_comb begin
        ready   = (state == ST_IDLE);
        active  = (state == ST_ACC);
        stall   = active && wait_en && mem_wait && (phase == hold_pt);
        last_ph = (phase == len - PH_W'(1));
        reject  = req_write && rd_only;
    end

    // Main state register, phase counter, release counter and done/err flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= '0;
            rel_cnt   <= '0;
            acc_write <= 1'b0;
            acc_lanes <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        acc_write <= req_write;
                        acc_lanes <= req_lanes;
                        rel_cnt   <= '0;
                        if (reject) begin
                            done  <= 1'b1;
                            err   <= 1'b1;
                            state <= rel_none ? ST_IDLE : ST_REL;
                        end else begin
                            phase <= '0;
                            state <= ST_ACC;
                        end
                    end
                end
                ST_ACC: begin
                    if (!stall) begin
                        if (last_ph) begin
                            done    <= 1'b1;
                            rel_cnt <= '0;
                            state   <= rel_none ? ST_IDLE : ST_REL;
                        end else begin
                            phase <= phase + PH_W'(1);
                        end
                    end
                end
                ST_REL: begin
                    if (rel_cnt == rel_len - RPH_W'(1))
                        state <= ST_IDLE;
                    else
                        rel_cnt <= rel_cnt + RPH_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/strobe_decode.sv
// Strobe decoder: turns the registered phase counter and access type into the
// active-low strobes, the write data-drive enable and the read capture pulse.
// Lanes above lane 0 are strobed only on a wide bus. An empty window leaves
// its strobe inactive.
module strobe_decode
    import strobe_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic              active,
    input  logic [PH_W-1:0]   phase,
    input  logic [PH_W-1:0]   len,
    input  logic              acc_write,
    input  logic [LANES-1:0]  acc_lanes,
    input  logic              stall,
    input  logic              bus_wide,
    input  logic [EDGE_W-1:0] ce_on,
    input  logic [EDGE_W-1:0] ce_off,
    input  logic [EDGE_W-1:0] oe_on,
    input  logic [EDGE_W-1:0] we_on,
    input  logic [EDGE_W-1:0] we_off,
    input  logic [DLY_W-1:0]  dly,
    output logic              ce_n,
    output logic              oe_n,
    output logic [LANES-1:0]  we_n,
    output logic              data_oe,
    output logic              rd_capture
);

    logic we_win;

    // Chip-enable and output-enable windows.
    always_comb begin
        ce_n = !(active && in_window(phase, ce_on, ce_off, len));
        oe_n = !(active && !acc_write && in_window(phase, oe_on, EDGE_W'(0), len));
    end

    // Shared write window before the per-lane qualification.
    always_comb we_win = active && acc_write && in_window(phase, we_on, we_off, len);

    // Write data drive from the delay point to the end; capture on the last read phase.
    always_comb begin
        data_oe    = active && acc_write && (phase >= PH_W'(dly));
        rd_capture = active && !acc_write && !stall && (phase == len - PH_W'(1));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_base
            // Lane 0 is strobed on any bus width.
            always_comb we_n[g] = !(we_win && acc_lanes[g]);
        end else begin : g_upper
            // Upper lanes are strobed only on a wide bus.
            always_comb we_n[g] = !(we_win && acc_lanes[g] && bus_wide);
        end
    end

endmodule

// File: rtl/mem_strobe_gen.sv
// Top level of the external memory strobe timing generator for one bank.
// Collects the configuration ports into one record and connects the
// configuration register, the access sequencer and the strobe decoder.
// Assumes clk ticks once per phase (half a bus cycle) and LANES >= 2.
module mem_strobe_gen
    import strobe_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BOOT_W-1:0] boot_src,
    input  logic              cfg_wr,
    input  logic [DUR_W-1:0]  cfg_dur,
    input  logic [EDGE_W-1:0] cfg_ce_on,
    input  logic [EDGE_W-1:0] cfg_ce_off,
    input  logic [EDGE_W-1:0] cfg_oe_on,
    input  logic [EDGE_W-1:0] cfg_we_on,
    input  logic [EDGE_W-1:0] cfg_we_off,
    input  logic [REL_W-1:0]  cfg_release,
    input  logic [DLY_W-1:0]  cfg_drive_dly,
    input  logic              cfg_wait_en,
    input  logic              cfg_read_only,
    input  logic              cfg_bus_wide,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_lanes,
    output logic              req_ready,
    input  logic              mem_wait,
    output logic              ce_n,
    output logic              oe_n,
    output logic [LANES-1:0]  we_n,
    output logic              data_oe,
    output logic              rd_capture,
    output logic              done,
    output logic              err,
    output logic              bus_wide
);

    cfg_t             cfg_in;
    cfg_t             cfg;
    logic             seq_active;
    logic [PH_W-1:0]  seq_phase;
    logic [PH_W-1:0]  seq_len;
    logic             seq_write;
    logic [LANES-1:0] seq_lanes;
    logic             seq_stall;

    // Gather the configuration input ports into one record.
    always_comb begin
        cfg_in.bus_wide = cfg_bus_wide;
        cfg_in.wait_en  = cfg_wait_en;
        cfg_in.rd_only  = cfg_read_only;
        cfg_in.dur      = cfg_dur;
        cfg_in.ce_on    = cfg_ce_on;
        cfg_in.ce_off   = cfg_ce_off;
        cfg_in.oe_on    = cfg_oe_on;
        cfg_in.we_on    = cfg_we_on;
        cfg_in.we_off   = cfg_we_off;
        cfg_in.rel      = cfg_release;
        cfg_in.dly      = cfg_drive_dly;
    end

    strobe_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_src (boot_src),
        .cfg_wr   (cfg_wr),
        .idle     (req_ready),
        .cfg_in   (cfg_in),
        .cfg      (cfg)
    );

    strobe_sequencer #(.LANES(LANES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dur       (cfg.dur),
        .ce_off    (cfg.ce_off),
        .we_off    (cfg.we_off),
        .rel       (cfg.rel),
        .wait_en   (cfg.wait_en),
        .rd_only   (cfg.rd_only),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_lanes (req_lanes),
        .mem_wait  (mem_wait),
        .ready     (req_ready),
        .active    (seq_active),
        .phase     (seq_phase),
        .len       (seq_len),
        .acc_write (seq_write),
        .acc_lanes (seq_lanes),
        .stall     (seq_stall),
        .done      (done),
        .err       (err)
    );

    strobe_decode #(.LANES(LANES)) u_dec (
        .active     (seq_active),
        .phase      (seq_phase),
        .len        (seq_len),
        .acc_write  (seq_write),
        .acc_lanes  (seq_lanes),
        .stall      (seq_stall),
        .bus_wide   (cfg.bus_wide),
        .ce_on      (cfg.ce_on),
        .ce_off     (cfg.ce_off),
        .oe_on      (cfg.oe_on),
        .we_on      (cfg.we_on),
        .we_off     (cfg.we_off),
        .dly        (cfg.dly),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .data_oe    (data_oe),
        .rd_capture (rd_capture)
    );

    // Expose the current bus width.
    always_comb bus_wide = cfg.bus_wide;

endmodule

// File: rtl/strobe_checker.sv
// Checker for the strobe timing generator, attached to the top by bind.
// Observes the ports plus the sequencer's stall signal.
module strobe_checker #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             ce_n,
    input logic             oe_n,
    input logic [LANES-1:0] we_n,
    input logic             data_oe,
    input logic             rd_capture,
    input logic             done,
    input logic             err,
    input logic             bus_wide,
    input logic             stall
);

    // R10: an idle block drives no strobe.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n && oe_n && (&we_n) && !data_oe && !rd_capture));

    // R3: done lasts one clock.
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: err only comes with done and never with a write strobe.
    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && (&we_n)));

    // R6: write strobes never overlap a read.
    assert_we_not_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(&we_n) |-> (oe_n && !rd_capture));

    // R7: no data drive while the output enable is active.
    assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !data_oe);

    // R8: a held phase keeps every strobe level.
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(ce_n) && $stable(oe_n) && $stable(we_n) && $stable(data_oe)));

    // R2: a narrow bus never strobes the upper lanes.
    assert_narrow_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wide |-> (&we_n[LANES-1:1]));

endmodule

bind mem_strobe_gen strobe_checker #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .data_oe    (data_oe),
    .rd_capture (rd_capture),
    .done       (done),
    .err        (err),
    .bus_wide   (bus_wide),
    .stall      (seq_stall)
);

// File: tb/sim_mem_strobe_gen.sv
`timescale 1ns/1ps
module sim_mem_strobe_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] boot_src;
    logic       cfg_wr;
    logic [3:0] cfg_dur, cfg_ce_on, cfg_ce_off, cfg_oe_on, cfg_we_on, cfg_we_off;
    logic [1:0] cfg_release;
    logic [2:0] cfg_drive_dly;
    logic       cfg_wait_en, cfg_read_only, cfg_bus_wide;
    logic       req_valid, req_write;
    logic [1:0] req_lanes;
    logic       req_ready, mem_wait;
    logic       ce_n, oe_n, data_oe, rd_capture, done, err, bus_wide;
    logic [1:0] we_n;

    int n_checks = 0;
    int n_fail   = 0;

    // 200 MHz phase clock.
    always #2.5 clk = ~clk;

    mem_strobe_gen #(.LANES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .boot_src(boot_src), .cfg_wr(cfg_wr),
        .cfg_dur(cfg_dur), .cfg_ce_on(cfg_ce_on), .cfg_ce_off(cfg_ce_off),
        .cfg_oe_on(cfg_oe_on), .cfg_we_on(cfg_we_on), .cfg_we_off(cfg_we_off),
        .cfg_release(cfg_release), .cfg_drive_dly(cfg_drive_dly),
        .cfg_wait_en(cfg_wait_en), .cfg_read_only(cfg_read_only),
        .cfg_bus_wide(cfg_bus_wide), .req_valid(req_valid), .req_write(req_write),
        .req_lanes(req_lanes), .req_ready(req_ready), .mem_wait(mem_wait),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .data_oe(data_oe),
        .rd_capture(rd_capture), .done(done), .err(err), .bus_wide(bus_wide)
    );

    typedef struct packed {
        logic       ce_n;
        logic       oe_n;
        logic [1:0] we_n;
        logic       doe;
        logic       cap;
        logic       done;
        logic       err;
        logic       ready;
    } exp_t;

    exp_t exp_q[$];

    // Configuration model, kept from the requirements.
    int m_dur, m_ce_on, m_ce_off, m_oe_on, m_we_on, m_we_off;
    int m_rel, m_dly, m_wen, m_ro, m_wide;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // Model of the reset defaults (R1).
    task automatic model_defaults(input int wide);
        m_dur = 10; m_ce_on = 0; m_ce_off = 0; m_oe_on = 0; m_we_on = 9;
        m_we_off = 2; m_rel = 2; m_dly = 5; m_wen = 1; m_ro = 0; m_wide = wide;
    endtask

    task automatic drive_cfg_inputs();
        cfg_dur = 4'(m_dur); cfg_ce_on = 4'(m_ce_on); cfg_ce_off = 4'(m_ce_off);
        cfg_oe_on = 4'(m_oe_on); cfg_we_on = 4'(m_we_on); cfg_we_off = 4'(m_we_off);
        cfg_release = 2'(m_rel); cfg_drive_dly = 3'(m_dly);
        cfg_wait_en = 1'(m_wen); cfg_read_only = 1'(m_ro); cfg_bus_wide = 1'(m_wide);
    endtask

    // Load a configuration while idle (R12, accepted case).
    task automatic cfg_set(input int dur, input int ceon, input int ceoff, input int oeon,
                           input int weon, input int weoff, input int rel, input int dly,
                           input int wen, input int ro, input int wide);
        m_dur = dur; m_ce_on = ceon; m_ce_off = ceoff; m_oe_on = oeon; m_we_on = weon;
        m_we_off = weoff; m_rel = rel; m_dly = dly; m_wen = wen; m_ro = ro; m_wide = wide;
        @(negedge clk);
        drive_cfg_inputs();
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Driver: builds the expected timeline, issues the request and pushes items.
    task automatic do_access(input bit wr, input logic [1:0] lanes, input int nwait,
                             input bit mid_cfg);
        int   len, off, hold, p, left;
        bit   mw, st;
        exp_t e;
        exp_t slots[$];
        bit   mws[$];
        len  = (m_dur == 0) ? 32 : 2 * m_dur;
        off  = (wr && (m_we_off > m_ce_off)) ? m_we_off : m_ce_off;
        hold = (len > off) ? (len - 1 - off) : 0;
        if (!(wr && m_ro != 0)) begin
            p = 0;
            left = nwait;
            while (p < len) begin
                mw = (p == hold) && (left > 0);
                if (mw) left--;
                st = mw && (m_wen != 0);
                e.ce_n    = !((p >= m_ce_on) && (p + m_ce_off < len));
                e.oe_n    = wr ? 1'b1 : !(p >= m_oe_on);
                for (int i = 0; i < 2; i++)
                    e.we_n[i] = !(wr && lanes[i] && (i == 0 || m_wide != 0) &&
                                  (p >= m_we_on) && (p + m_we_off < len));
                e.doe     = wr && (p >= m_dly);
                e.cap     = !wr && (p == len - 1) && !st;
                e.done    = 1'b0;
                e.err     = 1'b0;
                e.ready   = 1'b0;
                slots.push_back(e);
                mws.push_back(mw);
                if (!st) p++;
            end
        end
        // Done phase, release phases, then one idle phase.
        e = '{ce_n:1'b1, oe_n:1'b1, we_n:2'b11, doe:1'b0, cap:1'b0,
              done:1'b1, err:(wr && m_ro != 0), ready:(m_rel == 0)};
        slots.push_back(e); mws.push_back(1'b0);
        for (int s = 1; s < 2 * m_rel; s++) begin
            e.done = 1'b0; e.err = 1'b0; e.ready = 1'b0;
            slots.push_back(e); mws.push_back(1'b0);
        end
        e.done = 1'b0; e.err = 1'b0; e.ready = 1'b1;
        slots.push_back(e); mws.push_back(1'b0);

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_lanes = lanes;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        foreach (slots[i]) exp_q.push_back(slots[i]);
        foreach (mws[i]) begin
            @(negedge clk);
            mem_wait = mws[i];
            if (mid_cfg && i == 2) begin
                cfg_dur = 4'd1;  // R12: a write while busy must be ignored
                cfg_wr  = 1'b1;
            end else begin
                cfg_wr = 1'b0;
                drive_cfg_inputs();
            end
        end
        mem_wait = 1'b0;
        cfg_wr   = 1'b0;
        while (exp_q.size() != 0) #1;
    endtask

    // Monitor: pops one expected item per clock and compares every output.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(ce_n == e.ce_n, "R4", "ce_n", ce_n, e.ce_n);
                check(oe_n == e.oe_n, "R5", "oe_n", oe_n, e.oe_n);
                check(we_n == e.we_n, "R6", "we_n", we_n, e.we_n);
                check(data_oe == e.doe, "R7", "data_oe", data_oe, e.doe);
                check(rd_capture == e.cap, "R5", "rd_capture", rd_capture, e.cap);
                check(done == e.done, "R3", "done", done, e.done);
                check(err == e.err, "R9", "err", err, e.err);
                check(req_ready == e.ready, "R10", "req_ready", req_ready, e.ready);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    task automatic check_idle_state(input string tag);
        check(req_ready == 1'b1, tag, "req_ready", req_ready, 1);
        check({ce_n, oe_n, we_n} == 4'b1111, tag, "strobes", {ce_n, oe_n, we_n}, 15);
        check({data_oe, rd_capture, done, err} == 4'b0000, tag, "flags",
              {data_oe, rd_capture, done, err}, 0);
    endtask

    task automatic apply_reset(input logic [1:0] boot);
        @(negedge clk);
        rst_n = 1'b0; boot_src = boot;
        repeat (3) @(negedge clk);
        #1;
        check_idle_state("R1");            // R1: state during reset
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_idle_state("R1");            // R1: state after release
        check(bus_wide == (boot != 2'b01), "R2", "bus_wide", bus_wide, (boot != 2'b01));
        model_defaults(boot != 2'b01);
        drive_cfg_inputs();
    endtask

    initial begin
        rst_n = 1'b0; boot_src = 2'b10; cfg_wr = 1'b0; req_valid = 1'b0;
        req_write = 1'b0; req_lanes = 2'b00; mem_wait = 1'b0;
        model_defaults(1);
        drive_cfg_inputs();

        apply_reset(2'b10);
        // R1, R3, R4, R5, R10: default read timing.
        do_access(1'b0, 2'b00, 0, 1'b0);
        // R6, R7, R8: default write on both lanes with two held phases.
        do_access(1'b1, 2'b11, 2, 1'b0);

        // Short timing, zero release, non-zero strobe edges.
        cfg_set(4, 1, 1, 2, 2, 2, 0, 1, 1, 0, 1);
        do_access(1'b0, 2'b00, 3, 1'b0);   // R5, R8 read with wait
        do_access(1'b1, 2'b01, 1, 1'b0);   // R6 lane 0 only
        do_access(1'b1, 2'b10, 0, 1'b0);   // R6 lane 1 only, back to back

        // R8: wait disabled, mem_wait pulses must have no effect.
        cfg_set(4, 0, 1, 1, 1, 3, 1, 2, 0, 0, 1);
        do_access(1'b0, 2'b00, 2, 1'b0);
        do_access(1'b1, 2'b11, 2, 1'b0);

        // R3: zero duration gives the longest access.
        cfg_set(0, 3, 2, 4, 5, 6, 3, 7, 1, 0, 1);
        do_access(1'b0, 2'b00, 1, 1'b0);
        do_access(1'b1, 2'b11, 0, 1'b0);

        // R11: off point at or before on point keeps strobes inactive.
        cfg_set(4, 8, 8, 2, 6, 3, 1, 3, 1, 0, 1);
        do_access(1'b1, 2'b11, 0, 1'b0);
        do_access(1'b0, 2'b00, 0, 1'b0);

        // R9: write to a read-only bank, then a read that still works.
        cfg_set(3, 0, 0, 1, 1, 1, 1, 2, 1, 1, 1);
        do_access(1'b1, 2'b11, 0, 1'b0);
        do_access(1'b0, 2'b00, 0, 1'b0);
        cfg_set(3, 0, 0, 1, 1, 1, 0, 2, 1, 1, 1);
        do_access(1'b1, 2'b01, 0, 1'b0);   // R9 with zero release

        // R12: a write during an access is ignored; next access keeps old timing.
        cfg_set(5, 1, 0, 1, 2, 1, 1, 2, 1, 0, 1);
        do_access(1'b0, 2'b00, 0, 1'b1);
        do_access(1'b1, 2'b11, 0, 1'b0);

        // R2: narrow boot code; upper lane is never strobed.
        apply_reset(2'b01);
        do_access(1'b1, 2'b11, 0, 1'b0);
        apply_reset(2'b00);
        do_access(1'b1, 2'b10, 0, 1'b0);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule